// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a circular ring of transmit descriptors kept in a small descriptor store that the host and the engine share. Each descriptor is one 64-bit word carrying flag bits, a frame length and a buffer pointer. When the engine finds a descriptor that the host has marked ready, it offers the pointer, the length and the per-frame flags to a downstream MAC on a valid/ready handshake. The handshake completes when the frame has gone out. The engine then writes the descriptor back with its ready bit cleared and the MAC's completion status filled in, and moves on to the next descriptor.

The ring has no fixed length. A wrap flag in a descriptor makes it the last one, and the engine continues at the ring base after it. The engine stops in a halted state when it meets a descriptor that is not ready, and it stays there until the host pulses the restart strobe. The host can also ask for a graceful stop. In that case the frame already in flight completes, and the engine halts and signals that the stop is done. Only descriptor contents travel downstream. Buffer data, checksums and bus arbitration are handled elsewhere.

Descriptor word layout (bit positions): 63 ready, 62 reserved, 61 wrap, 60 interrupt, 59 last, 58 crc, 57:48 completion status, 47:32 length, 31:0 buffer pointer.

Top module: `tx_desc_ring`

## Requirements
- R1: After reset, thalt_o is 1, req_valid_o, irq_o and gstop_done_o are 0, and every descriptor reads back as zero.
- R2: The first restart strobe after reset makes the engine fetch from the index given on ring_base_i.
- R3: For a descriptor with ready (bit 63) set, the engine raises req_valid_o with req_ptr_o = bits 31:0, req_len_o = bits 47:32, req_crc_o = bit 58 and req_last_o = bit 59. These stay stable while req_ready_i is low.
- R4: On the cycle req_ready_i is accepted, the descriptor is rewritten in one write: bit 63 is cleared, bits 57:48 take tx_stat_i, and all other bits are unchanged.
- R5: irq_o pulses for one cycle, on the cycle after acceptance, exactly when the completed descriptor has interrupt (bit 60) set.
- R6: After a descriptor with wrap (bit 61) completes, the next fetch is at ring_base_i. Otherwise the next fetch is at the following index, modulo the ring store depth.
- R7: Fetching a descriptor with bit 63 clear halts the engine: thalt_o goes to 1 and no request is made. Setting that ready bit afterwards has no effect until halt_clr_i is pulsed.
- R8: A restart after a halt resumes at the descriptor that caused the halt, not at ring_base_i.
- R9: A pulse on gstop_i during a frame lets that frame complete and be written back. The engine then halts with a one-cycle gstop_done_o pulse, and it does not request the next descriptor even if that descriptor is ready.
- R10: halt_clr_i pulsed while the engine is running has no effect on the request in flight or on the order of descriptors.
- R11: A pulse on gstop_i while halted gives a gstop_done_o pulse on the next cycle, and the engine stays halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe for the descriptor store |
| host_addr_i | input | AW | Host descriptor index for reads and writes |
| host_wdata_i | input | 64 | Host descriptor write word |
| host_rdata_o | output | 64 | Descriptor at host_addr_i (combinational) |
| ring_base_i | input | AW | Ring base index |
| halt_clr_i | input | 1 | Restart strobe |
| gstop_i | input | 1 | Graceful stop request strobe |
| req_valid_o | output | 1 | Frame request valid |
| req_ready_i | input | 1 | Frame done / accepted |
| req_ptr_o | output | 32 | Buffer pointer |
| req_len_o | output | 16 | Frame length |
| req_crc_o | output | 1 | Append FCS |
| req_last_o | output | 1 | End of frame |
| tx_stat_i | input | 10 | Completion status from MAC |
| thalt_o | output | 1 | Engine halted |
| irq_o | output | 1 | Completion event pulse |
| gstop_done_o | output | 1 | Graceful stop complete pulse |

## Verification
A wrong ring index shows at the ports as the wrong pointer on the next request. It can also show as a request where a halt was expected, or a halt where a request was expected. Either way it appears within two cycles of the previous acceptance, which is why each descriptor in the ring carries a distinct pointer and a decoy sits at the entry the engine must not visit. A lost or misplaced write-back is visible on a host read in the cycle after acceptance. A stop or restart handled in the wrong state shows as req_valid_o or thalt_o being wrong a cycle later.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int PTR_W  = 32;
  localparam int LEN_W  = 16;
  localparam int STAT_W = 10;

  typedef struct packed {
    logic              rdy;
    logic              rsv;
    logic              wrap;
    logic              intr;
    logic              last;
    logic              crc;
    logic [STAT_W-1:0] stat;
    logic [LEN_W-1:0]  len;
    logic [PTR_W-1:0]  ptr;
  } txd_t;

  localparam int DESC_W = $bits(txd_t);

  typedef enum logic [1:0] {ST_HALT, ST_FETCH, ST_SEND} eng_st_e;
endpackage

// File: rtl/txr_desc_mem.sv
module txr_desc_mem
  import txr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              h_we_i,
  input  logic [AW-1:0]     h_addr_i,
  input  logic [DESC_W-1:0] h_wdata_i,
  output logic [DESC_W-1:0] h_rdata_o,
  input  logic [AW-1:0]     e_addr_i,
  output txd_t              e_rdata_o,
  input  logic              e_we_i,
  input  txd_t              e_wdata_i
);
  logic [DESC_W-1:0] mem_q [DEPTH];

  // engine write-back wins a same-index collision
  logic h_block;
  assign h_block = e_we_i && (e_addr_i == h_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (e_we_i) mem_q[e_addr_i] <= e_wdata_i;
      if (h_we_i && !h_block) mem_q[h_addr_i] <= h_wdata_i;
    end
  end

  assign h_rdata_o = mem_q[h_addr_i];
  assign e_rdata_o = txd_t'(mem_q[e_addr_i]);
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     ring_base_i,
  input  logic              halt_clr_i,
  input  logic              gstop_i,
  output logic [AW-1:0]     idx_o,
  input  txd_t              rd_desc_i,
  output logic              wb_we_o,
  output txd_t              wb_desc_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [PTR_W-1:0]  req_ptr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic              req_crc_o,
  output logic              req_last_o,
  input  logic [STAT_W-1:0] tx_stat_i,
  output logic              thalt_o,
  output logic              irq_o,
  output logic              gstop_done_o
);
  eng_st_e     st_q;
  logic [AW-1:0] idx_q;
  txd_t        cur_q;
  logic        fresh_q, gpend_q, thalt_q, irq_q, gdone_q;
  logic        stop_now, accept;
  logic [AW-1:0] idx_inc;

  assign stop_now = gpend_q | gstop_i;
  assign accept   = (st_q == ST_SEND) && req_ready_i;
  assign idx_inc  = (idx_q == AW'(DEPTH-1)) ? '0 : idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HALT;
      idx_q   <= '0;
      cur_q   <= '0;
      fresh_q <= 1'b1;
      gpend_q <= 1'b0;
      thalt_q <= 1'b1;
      irq_q   <= 1'b0;
      gdone_q <= 1'b0;
    end else begin
      irq_q   <= 1'b0;
      gdone_q <= 1'b0;
      if (gstop_i) gpend_q <= 1'b1;
      unique case (st_q)
        ST_HALT: begin
          if (stop_now) begin
            gdone_q <= 1'b1;
            gpend_q <= 1'b0;
          end else if (halt_clr_i) begin
            st_q    <= ST_FETCH;
            thalt_q <= 1'b0;
            fresh_q <= 1'b0;
            if (fresh_q) idx_q <= ring_base_i;
          end
        end
        ST_FETCH: begin
          if (stop_now) begin
            st_q    <= ST_HALT;
            thalt_q <= 1'b1;
            gdone_q <= 1'b1;
            gpend_q <= 1'b0;
          end else if (!rd_desc_i.rdy) begin
            st_q    <= ST_HALT;
            thalt_q <= 1'b1;
          end else begin
            cur_q <= rd_desc_i;
            st_q  <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (req_ready_i) begin
            irq_q <= cur_q.intr;
            idx_q <= cur_q.wrap ? ring_base_i : idx_inc;
            st_q  <= ST_FETCH;
          end
        end
        default: st_q <= ST_HALT;
      endcase
    end
  end

  always_comb begin
    wb_desc_o      = cur_q;
    wb_desc_o.rdy  = 1'b0;
    wb_desc_o.stat = tx_stat_i;
  end

  assign wb_we_o      = accept;
  assign idx_o        = idx_q;
  assign req_valid_o  = (st_q == ST_SEND);
  assign req_ptr_o    = cur_q.ptr;
  assign req_len_o    = cur_q.len;
  assign req_crc_o    = cur_q.crc;
  assign req_last_o   = cur_q.last;
  assign thalt_o      = thalt_q;
  assign irq_o        = irq_q;
  assign gstop_done_o = gdone_q;

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_ptr_o) && $stable(req_len_o));
  // R5
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(req_valid_o && req_ready_i));
  // R7
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thalt_o |-> !req_valid_o);
  // R9
  gdone_halted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gstop_done_o |-> thalt_o);
  // R6
  wrap_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && cur_q.wrap |=> idx_q == $past(ring_base_i));
endmodule

// File: rtl/tx_desc_ring.sv
module tx_desc_ring
  import txr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [AW-1:0]     host_addr_i,
  input  logic [63:0]       host_wdata_i,
  output logic [63:0]       host_rdata_o,
  input  logic [AW-1:0]     ring_base_i,
  input  logic              halt_clr_i,
  input  logic              gstop_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [31:0]       req_ptr_o,
  output logic [15:0]       req_len_o,
  output logic              req_crc_o,
  output logic              req_last_o,
  input  logic [9:0]        tx_stat_i,
  output logic              thalt_o,
  output logic              irq_o,
  output logic              gstop_done_o
);
  logic [AW-1:0] e_idx;
  txd_t          e_rd, e_wb;
  logic          e_we;

  txr_desc_mem #(.DEPTH(DEPTH)) i_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .h_we_i    (host_we_i),
    .h_addr_i  (host_addr_i),
    .h_wdata_i (host_wdata_i),
    .h_rdata_o (host_rdata_o),
    .e_addr_i  (e_idx),
    .e_rdata_o (e_rd),
    .e_we_i    (e_we),
    .e_wdata_i (e_wb)
  );

  txr_engine #(.DEPTH(DEPTH)) i_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ring_base_i  (ring_base_i),
    .halt_clr_i   (halt_clr_i),
    .gstop_i      (gstop_i),
    .idx_o        (e_idx),
    .rd_desc_i    (e_rd),
    .wb_we_o      (e_we),
    .wb_desc_o    (e_wb),
    .req_valid_o  (req_valid_o),
    .req_ready_i  (req_ready_i),
    .req_ptr_o    (req_ptr_o),
    .req_len_o    (req_len_o),
    .req_crc_o    (req_crc_o),
    .req_last_o   (req_last_o),
    .tx_stat_i    (tx_stat_i),
    .thalt_o      (thalt_o),
    .irq_o        (irq_o),
    .gstop_done_o (gstop_done_o)
  );
endmodule

// File: tb/test_tx_desc_ring.sv
module test_tx_desc_ring;
  localparam int DEPTH = 4;
  localparam int AW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 1'b0;
  logic [AW-1:0] host_addr = '0, ring_base = '0;
  logic [63:0] host_wdata = '0, host_rdata;
  logic halt_clr = 1'b0, gstop = 1'b0, req_ready = 1'b0;
  logic req_valid, req_crc, req_last, thalt, irq, gdone;
  logic [31:0] req_ptr;
  logic [15:0] req_len;
  logic [9:0] tx_stat = '0;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  tx_desc_ring #(.DEPTH(DEPTH)) i_tx_desc_ring (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata), .ring_base_i(ring_base),
    .halt_clr_i(halt_clr), .gstop_i(gstop), .req_valid_o(req_valid), .req_ready_i(req_ready),
    .req_ptr_o(req_ptr), .req_len_o(req_len), .req_crc_o(req_crc), .req_last_o(req_last),
    .tx_stat_i(tx_stat), .thalt_o(thalt), .irq_o(irq), .gstop_done_o(gdone));

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=50000", cyc);
      summary();
    end
  end

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input bit rdy, input bit wrap, input bit intr,
      input bit last, input bit crc, input logic [15:0] len, input logic [31:0] ptr);
    return {rdy, 1'b0, wrap, intr, last, crc, 10'h0, len, ptr};
  endfunction

  task automatic step(); @(negedge clk); endtask

  task automatic hwrite(input int a, input logic [63:0] d);
    host_addr = AW'(a); host_wdata = d; host_we = 1'b1;
    step();
    host_we = 1'b0;
  endtask

  task automatic hread(input int a, output logic [63:0] d);
    host_addr = AW'(a); #1 d = host_rdata;
  endtask

  task automatic pulse_clr(); halt_clr = 1'b1; step(); halt_clr = 1'b0; endtask

  // waits for a request, checks it, holds, acknowledges, checks write-back and irq
  task automatic do_frame(input string rq, input int idx, input logic [63:0] d,
                          input logic [9:0] st, input bit gs, input bit hc);
    int w = 0;
    logic [63:0] rb, exp;
    while (!req_valid && w < 20) begin step(); w++; end
    chk({rq, " R3 valid"}, 64'(req_valid), 64'd1);
    chk({rq, " R3 ptr"}, 64'(req_ptr), 64'(d[31:0]));
    chk({rq, " R3 len"}, 64'(req_len), 64'(d[47:32]));
    chk({rq, " R3 crc/last"}, 64'({req_crc, req_last}), 64'({d[58], d[59]}));
    gstop = gs; halt_clr = hc;
    step();
    gstop = 1'b0; halt_clr = 1'b0;
    step();
    chk({rq, " R3 hold"}, 64'({req_valid, req_ptr}), 64'({1'b1, d[31:0]}));
    tx_stat = st; req_ready = 1'b1;
    step();
    req_ready = 1'b0;
    chk({rq, " R5 irq"}, 64'(irq), 64'(d[60]));
    exp = d; exp[63] = 1'b0; exp[57:48] = st;
    hread(idx, rb);
    chk({rq, " R4 writeback"}, rb, exp);
    step();
    chk({rq, " R5 irq pulse"}, 64'(irq), 64'd0);
  endtask

  task automatic expect_halt(input string rq);
    repeat (3) step();
    chk({rq, " thalt"}, 64'(thalt), 64'd1);
    chk({rq, " no req"}, 64'(req_valid), 64'd0);
  endtask

  task automatic t_reset();
    logic [63:0] rb;
    chk("R1 thalt", 64'(thalt), 64'd1);
    chk("R1 outputs", 64'({req_valid, irq, gdone}), 64'd0);
    for (int i = 0; i < DEPTH; i++) begin
      hread(i, rb);
      chk("R1 store zero", rb, 64'd0);
    end
  endtask

  logic [63:0] d1, d2, d3;

  task automatic t_ring();
    d1 = mk(1, 0, 1, 1, 1, 16'd64, 32'hA000_0010);
    d2 = mk(1, 0, 0, 1, 0, 16'd100, 32'hA000_0020);
    d3 = mk(1, 1, 1, 0, 1, 16'd1500, 32'hA000_0030);
    hwrite(0, mk(1, 0, 0, 0, 0, 16'd9, 32'hDEAD_0000)); // decoy
    hwrite(1, d1); hwrite(2, d2); hwrite(3, d3);
    ring_base = 2'd1;
    pulse_clr();
    do_frame("R2 first", 1, d1, 10'h005, 0, 0);
    do_frame("R6 next", 2, d2, 10'h000, 0, 0);
    do_frame("R6 wrapdesc", 3, d3, 10'h3FF, 0, 0);
    expect_halt("R6 R7 back at base");
  endtask

  task automatic t_hold_resume();
    d1 = mk(1, 0, 1, 0, 0, 16'd77, 32'hB000_0010);
    hwrite(1, d1);
    ring_base = 2'd2;
    expect_halt("R7 ready set while halted");
    pulse_clr();
    do_frame("R8 resume", 1, d1, 10'h011, 0, 0);
    expect_halt("R7 empty at 2");
  endtask

  task automatic t_clr_running();
    d2 = mk(1, 0, 0, 0, 1, 16'd60, 32'hC000_0020);
    d3 = mk(1, 1, 0, 1, 0, 16'd61, 32'hC000_0030);
    hwrite(2, d2); hwrite(3, d3);
    pulse_clr();
    do_frame("R10 clr in flight", 2, d2, 10'h002, 0, 1);
    do_frame("R10 order kept", 3, d3, 10'h003, 0, 0);
    expect_halt("R10 R6 wrap to base 2");
  endtask

  task automatic t_gstop();
    logic [63:0] rb;
    d2 = mk(1, 0, 1, 1, 1, 16'd40, 32'hD000_0020);
    d3 = mk(1, 1, 0, 1, 1, 16'd41, 32'hD000_0030);
    hwrite(2, d2); hwrite(3, d3);
    pulse_clr();
    do_frame("R9 frame completes", 2, d2, 10'h0AA, 1, 0);
    chk("R9 done pulse", 64'(gdone), 64'd1);
    chk("R9 halted", 64'(thalt), 64'd1);
    step();
    chk("R9 pulse one cycle", 64'(gdone), 64'd0);
    expect_halt("R9 next not requested");
    hread(3, rb);
    chk("R9 next untouched", rb, d3);
    gstop = 1'b1; step(); gstop = 1'b0;
    chk("R11 done while halted", 64'(gdone), 64'd1);
    step();
    chk("R11 pulse ends", 64'(gdone), 64'd0);
    expect_halt("R11 stays halted");
    pulse_clr();
    do_frame("R8 resume after stop", 3, d3, 10'h155, 0, 0);
    expect_halt("R7 final");
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_ring();
    t_hold_resume();
    t_clr_running();
    t_gstop();
    summary();
  end
endmodule